// File: doc/BRIEF.md
# Self-Shrinking Keystream Generator

This block produces a pseudorandom keystream at a variable rate. One Fibonacci shift register generates a raw bit stream. The raw bits are taken in non-overlapping pairs, and the first bit of each pair decides what happens to the second. When the first bit is 1, the second bit becomes one keystream bit. When the first bit is 0, the pair is dropped. The register advances two steps on every enabled clock, so each enabled clock evaluates exactly one pair. The result of that pair appears at the outputs on the next cycle, as a one-cycle `out_valid` pulse carrying `out_bit`.

A controller loads a seed word with `load_seed` and then holds `enable` high for as long as it wants keystream. It collects `out_bit` on every cycle where `out_valid` is high. On average about half of the enabled cycles produce a bit. The register width, the feedback tap mask, the reset seed and the substitute fill for an all-zero seed are all parameters. The default is an 8-stage register with feedback polynomial x^8 + x^4 + x^3 + x^2 + 1.

The decision logic is a small state machine whose state records the outcome of the most recent cycle:
- `ST_IDLE`: no pair was evaluated, because of reset, a seed load or enable low.
- `ST_DROP`: the pair was dropped.
- `ST_EMIT0`: a 1,0 pair was found.
- `ST_EMIT1`: a 1,1 pair was found.

Transitions:
- A seed load leads to `ST_IDLE` from any state, and so does a cycle with enable low.
- An enabled cycle leads to `ST_DROP`, `ST_EMIT0` or `ST_EMIT1`, chosen by the pair being evaluated.
- Reset forces `ST_IDLE`.

Top module: `ssg_keystream`

## Requirements
- R1: After synchronous reset the register holds the default seed 8'b1011_0110 (bit 7 is stage 8, bit 0 is stage 1), and `out_valid` and `out_bit` are 0.
- R2: One register step emits stage 1 (bit 0) as the raw bit, shifts every stage one place toward stage 1, and loads stage 8 with the XOR of stages 8, 4, 3 and 2 (tap mask 8'b1000_1110).
- R3: Each cycle with `enable` high and `load_seed` low consumes exactly two raw bits in order, as one pair that does not overlap any other pair. The next enabled cycle continues with the following two raw bits.
- R4: A pair of 1 then 0 gives `out_valid`=1 and `out_bit`=0 in the cycle after the enabled cycle.
- R5: A pair of 1 then 1 gives `out_valid`=1 and `out_bit`=1 in the cycle after the enabled cycle.
- R6: A pair whose first bit is 0 gives `out_valid`=0 in the cycle after. `out_bit` is 0 whenever `out_valid` is 0.
- R7: With `enable` and `load_seed` both low, the register keeps its value and `out_valid` is 0 in the next cycle. A later enabled cycle resumes the raw stream where it stopped.
- R8: `load_seed` takes priority over `enable`. The register takes `seed` on that clock, no pair is evaluated, and `out_valid` is 0 in the next cycle.
- R9: Loading an all-zero seed places the lock-up fill in the register instead (default: the reset seed 8'b1011_0110).
- R10: From the default seed, the first enabled cycle gives no output (pair 0,1), and the second gives a single keystream bit 0 (pair 1,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Evaluate one raw pair this cycle |
| load_seed | input | 1 | Load `seed` into the register; overrides `enable` |
| seed | input | WIDTH | Seed word; bit 0 is stage 1 |
| out_valid | output | 1 | High for one cycle when a pair produced a keystream bit |
| out_bit | output | 1 | Keystream bit, meaningful when `out_valid` is high |

## Verification
Any corruption of the register shows up at the ports within a few enabled cycles:
- A wrong tap or a wrong shift direction changes the raw stream, so the valid pattern or the emitted bits diverge from the bit-serial model.
- A pair misaligned by one raw bit swaps control and data roles, so it fails on the second enabled cycle after the default seed.
- An outcome state that lingers past its cycle appears as an extra `out_valid` pulse in the very next idle or load cycle.
- A dropped or wrongly substituted seed is exposed by the next few output bits after the load.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    // Outcome of the most recent cycle; doubles as the output state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DROP  = 2'd1,
        ST_EMIT0 = 2'd2,
        ST_EMIT1 = 2'd3
    } pair_state_e;

    // Raw bits consumed per enabled cycle.
    localparam int unsigned PAIR_LEN = 2;

endpackage

// File: rtl/ssg_lfsr_step.sv
// One combinational Fibonacci step: stage 1 (bit 0) leaves as the raw bit,
// the top stage is refilled with the parity of the tapped stages.
module ssg_lfsr_step #(
    parameter int unsigned     WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'b1000_1110
) (
    input  logic [WIDTH-1:0] cur_state,
    output logic [WIDTH-1:0] next_state,
    output logic             raw_bit
);

    logic [WIDTH-1:0] tapped;
    logic             feedback;

    always_comb begin
        tapped     = cur_state & TAPS;
        feedback   = ^tapped;
        raw_bit    = cur_state[0];
        next_state = {feedback, cur_state[WIDTH-1:1]};
    end

endmodule

// File: rtl/ssg_pair_decide.sv
// Classifies one raw pair: the leading bit gates, the trailing bit is data.
module ssg_pair_decide
    import ssg_pkg::*;
(
    input  logic        gate_bit,
    input  logic        data_bit,
    output pair_state_e verdict
);

    always_comb begin
        unique case ({gate_bit, data_bit})
            2'b10:   verdict = ST_EMIT0;
            2'b11:   verdict = ST_EMIT1;
            default: verdict = ST_DROP;
        endcase
    end

endmodule

// File: rtl/ssg_keystream.sv
module ssg_keystream
    import ssg_pkg::*;
#(
    parameter int unsigned      WIDTH        = 8,
    parameter logic [WIDTH-1:0] TAPS         = 8'b1000_1110,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = 8'b1011_0110,
    parameter logic [WIDTH-1:0] LOCKUP_FILL  = 8'b1011_0110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             load_seed,
    input  logic [WIDTH-1:0] seed,
    output logic             out_valid,
    output logic             out_bit
);

    localparam int unsigned STEPS = PAIR_LEN;

    logic [WIDTH-1:0] lfsr_q;
    logic [WIDTH-1:0] lfsr_d;
    logic [WIDTH-1:0] chain [0:STEPS];
    logic             raw   [0:STEPS-1];
    logic [WIDTH-1:0] seed_fill;
    pair_state_e      state_q;
    pair_state_e      state_d;
    pair_state_e      pair_verdict;

    // Two chained steps per enabled cycle.
    assign chain[0] = lfsr_q;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        ssg_lfsr_step #(
            .WIDTH (WIDTH),
            .TAPS  (TAPS)
        ) u_step (
            .cur_state  (chain[g]),
            .next_state (chain[g+1]),
            .raw_bit    (raw[g])
        );
    end

    ssg_pair_decide u_decide (
        .gate_bit (raw[0]),
        .data_bit (raw[1]),
        .verdict  (pair_verdict)
    );

    // An all-zero seed would freeze the register; substitute the fill.
    assign seed_fill = (seed == '0) ? LOCKUP_FILL : seed;

    // Next register value and next state.
    always_comb begin
        lfsr_d  = lfsr_q;
        state_d = ST_IDLE;
        if (load_seed) begin
            lfsr_d  = seed_fill;
            state_d = ST_IDLE;
        end else if (enable) begin
            lfsr_d  = chain[STEPS];
            state_d = pair_verdict;
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q  <= DEFAULT_SEED;
            state_q <= ST_IDLE;
        end else begin
            lfsr_q  <= lfsr_d;
            state_q <= state_d;
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_EMIT0: begin out_valid = 1'b1; out_bit = 1'b0; end
            ST_EMIT1: begin out_valid = 1'b1; out_bit = 1'b1; end
            ST_DROP:  begin out_valid = 1'b0; out_bit = 1'b0; end
            default:  begin out_valid = 1'b0; out_bit = 1'b0; end
        endcase
    end

endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
    parameter int unsigned      WIDTH        = 8,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = 8'b1011_0110,
    parameter logic [WIDTH-1:0] LOCKUP_FILL  = 8'b1011_0110
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             load_seed,
    input logic [WIDTH-1:0] seed,
    input logic             out_valid,
    input logic             out_bit,
    input logic [WIDTH-1:0] lfsr_q
);

    AST_RESET_SEED: assert property (@(posedge clk)
        rst |=> (lfsr_q == DEFAULT_SEED) && !out_valid); // R1

    AST_GATE_ZERO_DROPS: assert property (@(posedge clk) disable iff (rst)
        enable && !load_seed && !lfsr_q[0] |=> !out_valid); // R6

    AST_GATE_ONE_EMITS: assert property (@(posedge clk) disable iff (rst)
        enable && !load_seed && lfsr_q[0] |=> out_valid); // R4

    AST_BIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_bit); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enable && !load_seed |=> $stable(lfsr_q) && !out_valid); // R7

    AST_LOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (rst)
        load_seed && (seed != '0) |=> (lfsr_q == $past(seed)) && !out_valid); // R8

    AST_ZERO_SEED_FILL: assert property (@(posedge clk) disable iff (rst)
        load_seed && (seed == '0) |=> (lfsr_q == LOCKUP_FILL)); // R9

endmodule

bind ssg_keystream ssg_checker #(
    .WIDTH        (WIDTH),
    .DEFAULT_SEED (DEFAULT_SEED),
    .LOCKUP_FILL  (LOCKUP_FILL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .load_seed (load_seed),
    .seed      (seed),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .lfsr_q    (lfsr_q)
);

// File: tb/ssg_keystream_tb.sv
`timescale 1ns/1ps
module ssg_keystream_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       load_seed;
    logic [7:0] seed;
    logic       out_valid;
    logic       out_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bit-serial reference: stage[1] is the output end.
    bit stage [1:8];
    bit exp_v;
    bit exp_b;

    always #2.5 clk = ~clk;

    ssg_keystream u_dut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .load_seed (load_seed),
        .seed      (seed),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    function automatic void model_seed(input logic [7:0] s);
        logic [7:0] v;
        v = (s == 8'h00) ? 8'hB6 : s;
        for (int i = 1; i <= 8; i++) stage[i] = v[i-1];
    endfunction

    function automatic bit model_step();
        bit outb;
        bit fb;
        outb = stage[1];
        fb = stage[8] ^ stage[4] ^ stage[3] ^ stage[2];
        for (int i = 1; i < 8; i++) stage[i] = stage[i+1];
        stage[8] = fb;
        return outb;
    endfunction

    task automatic chk(input string req, input bit act_v, input bit act_b,
                       input bit e_v, input bit e_b);
        n_checks++;
        if (act_v !== e_v || act_b !== e_b) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b bit=%0b, expected valid=%0b bit=%0b",
                     req, act_v, act_b, e_v, e_b);
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic cycle(input bit en, input bit ld, input logic [7:0] sd,
                         input string req);
        bit a;
        bit b;
        @(negedge clk);
        enable = en; load_seed = ld; seed = sd;
        if (ld) begin
            model_seed(sd); exp_v = 0; exp_b = 0;
        end else if (en) begin
            a = model_step(); b = model_step();
            exp_v = a; exp_b = a & b;
        end else begin
            exp_v = 0; exp_b = 0;
        end
        @(posedge clk); #1;
        chk(req, out_valid, out_bit, exp_v, exp_b);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int lcg;
        rst = 1; enable = 0; load_seed = 0; seed = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 reset outputs", out_valid, out_bit, 0, 0);
        model_seed(8'hB6);

        // R10 / R4: known first pairs from default seed (0,1 then 1,0).
        cycle(1, 0, 8'h00, "R10 first pair dropped");
        chk("R10 first pair hard", out_valid, out_bit, 0, 0);
        cycle(1, 0, 8'h00, "R10 R4 second pair emits 0");
        chk("R10 second hard", out_valid, out_bit, 1, 0);

        // R7: hold then resume.
        cycle(0, 0, 8'h00, "R7 idle no valid");
        cycle(0, 0, 8'h00, "R7 idle no valid");
        for (int i = 0; i < 6; i++) cycle(1, 0, 8'h00, "R7 R3 resume stream");

        // R5: seed 0000_0011 yields raw 1,1.
        cycle(0, 1, 8'h03, "R8 load no valid");
        cycle(1, 0, 8'h00, "R5 pair 11 emits 1");
        chk("R5 hard", out_valid, out_bit, 1, 1);

        // R8: load beats enable.
        cycle(1, 1, 8'h5A, "R8 load priority");
        for (int i = 0; i < 8; i++) cycle(1, 0, 8'h00, "R8 R2 stream after load");

        // R9: zero seed reproduces the reset stream.
        cycle(0, 1, 8'h00, "R9 zero seed load");
        cycle(1, 0, 8'h00, "R9 first pair dropped");
        cycle(1, 0, 8'h00, "R9 second pair emits 0");
        chk("R9 hard", out_valid, out_bit, 1, 0);

        // Mixed stimulus against the model.
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            bit en;
            bit ld;
            lcg = lcg * 1103515245 + 12345;
            en = ((lcg >>> 16) & 3) != 0;
            ld = ((lcg >>> 18) & 31) == 0;
            cycle(en, ld, ((lcg >>> 20) & 7) == 0 ? 8'h00 : 8'((lcg >>> 8) & 255),
                  "R2 R3 R4 R5 R6 R7 R8 mixed");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule